// File: doc/BRIEF.md
# Codec Response Ring Status Controller

This block sits between the serial codec link and the memory system. At each frame strobe, a response slot on each serial input may hold a response word. The block takes the valid words into a small internal queue, lower input index first. It then offers them, one per beat, on a valid/ready memory-write port that fills a 256-entry ring of 64-bit entries. The ring address is produced by a write pointer. The pointer steps once for each accepted beat and wraps from 255 back to 0.

The block keeps a byte-wide status register with two write-one-to-clear flags and drives one interrupt line.

- The response flag rises when one of two events comes first:
  - a programmed number of responses has been written to the ring, or
  - a frame shows an empty slot on every serial input after at least one response was written.
- The overrun flag rises when a response arrives and the queue has no room for it. That response is dropped.

A small register port reads and writes the status, a fixed ring-size descriptor, a control byte and the response threshold.

Top module: `rsp_ring_ctrl`

## Requirements
- R1: The size register (address 1) always reads 8'h42: bits 7:4 = 4'b0100 and bits 1:0 = 2'b10. Writes to it have no effect.
- R2: Each valid response is written to the ring exactly once and with unchanged data. Responses keep frame order, and within one frame the lower input index goes first. While mem_wvalid is high and mem_wready is low, mem_wvalid, mem_wdata and mem_waddr hold steady.
- R3: The ring address starts at 0 and steps by one for each accepted beat (mem_wvalid and mem_wready both high). It wraps from 255 to 0.
- R4: Writing control (address 2) with bit 7 set returns the ring address to 0 on the next cycle. Bit 7 reads back as 0.
- R5: The queue holds 4 responses. At a frame strobe, room is judged from the queue fill level before that edge. Responses beyond the room are discarded, never reach the ring, and set status bit 2.
- R6: Status bit 0 sets on the beat that brings the written-response count to the threshold N (address 3). N = 0 means 256.
- R7: A frame strobe with all slot valids low sets status bit 0 only if at least one response was written since the previous frame strobe. An idle frame with no writes in between leaves the bit unchanged.
- R8: Both flags set whether or not they are enabled. irq is high exactly when a set flag has its enable set: control bit 0 enables bit 0 and control bit 2 enables bit 2.
- R9: Writing status (address 0) with a 1 in bit 0 or bit 2 clears that flag. A 0 leaves the flag unchanged. Bits 7:3 and bit 1 read as zero.
- R10: When a flag is set and cleared in the same cycle, the flag ends up 1.
- R11: A status write with bit 0 = 1 restarts the written-response count from zero.
- R12: After reset, status, control, threshold, irq and mem_wvalid are all 0, and mem_waddr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_stb | input | 1 | One-cycle frame strobe that qualifies the slot valids and words |
| slot_vld | input | NUM_IN | Per-input response-present flags for this frame |
| slot_data | input | NUM_IN*DW | Response words; input i occupies bits i*DW +: DW |
| mem_wvalid | output | 1 | Ring write request |
| mem_wready | input | 1 | Ring write accepted |
| mem_waddr | output | RING_AW | Ring entry index |
| mem_wdata | output | DW | Response word to write |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 status, 1 size, 2 control, 3 threshold |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| status | output | 8 | Status register contents |
| irq | output | 1 | Interrupt line |

## Verification
A frame strobe sampled at edge E shows up as mem_wvalid and head data just after E, and the overrun flag is also updated at E. With mem_wready high, the k-th queued word is written at edge E+k, and a count-threshold hit moves status bit 0 at that same edge. Empty-frame detection, register writes and pointer clears all take effect at the edge that samples them, and irq follows the flags with no added delay. The bench drives inputs shortly after a rising edge and samples on the falling edge. It waits several cycles beyond the last expected beat before it checks any count-dependent value.

// File: rtl/rsp_ring_pkg.sv
package rsp_ring_pkg;
    localparam logic [7:0] SIZE_DESC = 8'h42;

    typedef enum logic [1:0] {
        RA_STATUS = 2'd0,
        RA_SIZE   = 2'd1,
        RA_CTRL   = 2'd2,
        RA_THRESH = 2'd3
    } reg_addr_e;

    localparam int FLAG_RSP    = 0;
    localparam int FLAG_OVR    = 2;
    localparam int CTRL_PTRCLR = 7;
endpackage

// File: rtl/rsp_fifo.sv
module rsp_fifo #(
    parameter int NUM_IN = 3,
    parameter int DW     = 64,
    parameter int DEPTH  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push_stb,
    input  logic [NUM_IN-1:0]    push_vld,
    input  logic [NUM_IN*DW-1:0] push_data,
    input  logic                 pop,
    output logic                 head_vld,
    output logic [DW-1:0]        head_data,
    output logic                 drop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wr_ptr;
        logic [AW-1:0]            rd_ptr;
        logic [CW-1:0]            count;
    } fifo_st_t;

    fifo_st_t s_d, s_q;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        int room;
        int n_push;
        logic [AW-1:0] wp;
        s_d    = s_q;
        drop   = 1'b0;
        room   = DEPTH - 32'(s_q.count);
        n_push = 0;
        wp     = s_q.wr_ptr;
        if (pop) begin
            s_d.rd_ptr = ptr_inc(s_q.rd_ptr);
        end
        if (push_stb) begin
            for (int i = 0; i < NUM_IN; i++) begin
                if (push_vld[i]) begin
                    if (n_push < room) begin
                        s_d.mem[wp] = push_data[i*DW +: DW];
                        wp          = ptr_inc(wp);
                        n_push      = n_push + 1;
                    end else begin
                        drop = 1'b1;
                    end
                end
            end
        end
        s_d.wr_ptr = wp;
        s_d.count  = CW'(32'(s_q.count) + n_push - (pop ? 1 : 0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head_vld  = (s_q.count != '0);
    assign head_data = s_q.mem[s_q.rd_ptr];

    a_r5_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(s_q.count) <= DEPTH);

    a_r5_drop_leaves_full: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (32'(s_q.count) >= DEPTH - 1));

    a_r2_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (head_vld && !pop) |=> (head_vld && $stable(head_data)));
endmodule

// File: rtl/rsp_ring_wr.sv
module rsp_ring_wr #(
    parameter int RING_AW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               beat,
    input  logic               ptr_clr,
    output logic [RING_AW-1:0] waddr
);
    typedef struct packed {
        logic [RING_AW-1:0] ptr;
    } ring_st_t;

    ring_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ptr_clr) begin
            s_d.ptr = '0;
        end else if (beat) begin
            s_d.ptr = s_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign waddr = s_q.ptr;

    a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !ptr_clr) |=> (waddr == $past(waddr) + 1'b1));

    a_r4_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr |=> (waddr == '0));

    a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat && !ptr_clr) |=> $stable(waddr));
endmodule

// File: rtl/rsp_status.sv
module rsp_status
    import rsp_ring_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       beat,
    input  logic       frm_stb,
    input  logic       any_slot,
    input  logic       drop,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] status_byte,
    output logic [7:0] ctrl_byte,
    output logic [7:0] thresh_byte,
    output logic       ptr_clr,
    output logic       irq
);
    typedef struct packed {
        logic       rsp;
        logic       ovr;
        logic       en_rsp;
        logic       en_ovr;
        logic [7:0] thresh;
        logic [8:0] cnt;
        logic       armed;
    } st_t;

    st_t  s_d, s_q;
    logic wr_status, clr_rsp, clr_ovr, set_rsp, hit_cnt, hit_empty;
    logic [8:0] n_eff;

    always_comb begin
        s_d       = s_q;
        wr_status = reg_we && (reg_addr == RA_STATUS);
        clr_rsp   = wr_status && reg_wdata[FLAG_RSP];
        clr_ovr   = wr_status && reg_wdata[FLAG_OVR];
        ptr_clr   = reg_we && (reg_addr == RA_CTRL) && reg_wdata[CTRL_PTRCLR];
        n_eff     = (s_q.thresh == 8'd0) ? 9'd256 : {1'b0, s_q.thresh};
        hit_cnt   = beat && ((s_q.cnt + 9'd1) == n_eff);
        hit_empty = frm_stb && !any_slot && s_q.armed;
        set_rsp   = hit_cnt || hit_empty;

        if (clr_rsp) begin
            s_d.cnt = '0;
        end else if (beat && (s_q.cnt != 9'd256)) begin
            s_d.cnt = s_q.cnt + 9'd1;
        end

        if (frm_stb) begin
            s_d.armed = beat;
        end else if (beat) begin
            s_d.armed = 1'b1;
        end

        s_d.rsp = set_rsp || (s_q.rsp && !clr_rsp);
        s_d.ovr = drop || (s_q.ovr && !clr_ovr);

        if (reg_we && (reg_addr == RA_CTRL)) begin
            s_d.en_rsp = reg_wdata[FLAG_RSP];
            s_d.en_ovr = reg_wdata[FLAG_OVR];
        end
        if (reg_we && (reg_addr == RA_THRESH)) begin
            s_d.thresh = reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign status_byte = {5'b0, s_q.ovr, 1'b0, s_q.rsp};
    assign ctrl_byte   = {5'b0, s_q.en_ovr, 1'b0, s_q.en_rsp};
    assign thresh_byte = s_q.thresh;
    assign irq         = (s_q.rsp && s_q.en_rsp) || (s_q.ovr && s_q.en_ovr);

    a_r10_rsp_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_rsp |=> status_byte[FLAG_RSP]);

    a_r5_ovr_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> status_byte[FLAG_OVR]);

    a_r11_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rsp |=> (s_q.cnt == '0));

    a_r9_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!drop && !status_byte[FLAG_OVR]) |=> !status_byte[FLAG_OVR]);
endmodule

// File: rtl/rsp_ring_ctrl.sv
module rsp_ring_ctrl
    import rsp_ring_pkg::*;
#(
    parameter int NUM_IN  = 3,
    parameter int DW      = 64,
    parameter int DEPTH   = 4,
    parameter int RING_AW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frm_stb,
    input  logic [NUM_IN-1:0]    slot_vld,
    input  logic [NUM_IN*DW-1:0] slot_data,
    output logic                 mem_wvalid,
    input  logic                 mem_wready,
    output logic [RING_AW-1:0]   mem_waddr,
    output logic [DW-1:0]        mem_wdata,
    input  logic                 reg_we,
    input  logic [1:0]           reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    output logic [7:0]           status,
    output logic                 irq
);
    logic       beat, drop, ptr_clr;
    logic [7:0] ctrl_byte, thresh_byte;

    assign beat = mem_wvalid && mem_wready;

    rsp_fifo #(.NUM_IN(NUM_IN), .DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_stb  (frm_stb),
        .push_vld  (slot_vld),
        .push_data (slot_data),
        .pop       (beat),
        .head_vld  (mem_wvalid),
        .head_data (mem_wdata),
        .drop      (drop)
    );

    rsp_ring_wr #(.RING_AW(RING_AW)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .beat    (beat),
        .ptr_clr (ptr_clr),
        .waddr   (mem_waddr)
    );

    rsp_status u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .beat        (beat),
        .frm_stb     (frm_stb),
        .any_slot    (|slot_vld),
        .drop        (drop),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .status_byte (status),
        .ctrl_byte   (ctrl_byte),
        .thresh_byte (thresh_byte),
        .ptr_clr     (ptr_clr),
        .irq         (irq)
    );

    always_comb begin
        case (reg_addr)
            RA_STATUS: reg_rdata = status;
            RA_SIZE:   reg_rdata = SIZE_DESC;
            RA_CTRL:   reg_rdata = ctrl_byte;
            default:   reg_rdata = thresh_byte;
        endcase
    end

    a_r2_wvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_wdata)));

    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status[FLAG_RSP] || status[FLAG_OVR]));
endmodule

// File: tb/rsp_ring_ctrl_bench.sv
module rsp_ring_ctrl_bench;
    localparam int NUM_IN = 3;
    localparam int DW     = 64;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 frm_stb = 1'b0;
    logic [NUM_IN-1:0]    slot_vld = '0;
    logic [NUM_IN*DW-1:0] slot_data = '0;
    logic                 mem_wvalid;
    logic                 mem_wready = 1'b1;
    logic [7:0]           mem_waddr;
    logic [DW-1:0]        mem_wdata;
    logic                 reg_we = 1'b0;
    logic [1:0]           reg_addr = 2'd0;
    logic [7:0]           reg_wdata = 8'd0;
    logic [7:0]           reg_rdata;
    logic [7:0]           status;
    logic                 irq;

    int checks = 0;
    int failures = 0;
    int nbeats = 0;
    logic [DW-1:0] seq_log [0:511];
    logic [DW-1:0] ring_log [0:255];
    logic [DW-1:0] dseed = 64'hC0DE_0000_0000_0000;

    always #4 clk = ~clk;

    rsp_ring_ctrl u_rsp_ring_ctrl (
        .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .slot_vld(slot_vld),
        .slot_data(slot_data), .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .status(status), .irq(irq)
    );

    // beat happens at the next rising edge; inputs are stable at the falling edge
    always @(negedge clk) begin
        if (rst_n && mem_wvalid && mem_wready) begin
            seq_log[nbeats % 512] = mem_wdata;
            ring_log[mem_waddr]   = mem_wdata;
            nbeats = nbeats + 1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        @(posedge clk); #2;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    // one frame; returns the words used (lane i gets dseed+i)
    task automatic frame(input logic [NUM_IN-1:0] v, input logic wr_st, input logic [7:0] st_d,
                         output logic [DW-1:0] w0, output logic [DW-1:0] w1, output logic [DW-1:0] w2);
        @(posedge clk); #2;
        w0 = dseed; w1 = dseed + 1; w2 = dseed + 2;
        dseed = dseed + 3;
        slot_data = {w2, w1, w0};
        slot_vld = v; frm_stb = 1'b1;
        if (wr_st) begin
            reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = st_d;
        end
        @(posedge clk); #2;
        frm_stb = 1'b0; slot_vld = '0; reg_we = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R12 status", status, 8'h00);
        chk("R12 irq", irq, 0);
        chk("R12 wvalid", mem_wvalid, 0);
        chk("R12 waddr", mem_waddr, 0);
        reg_rd(2'd2, d); chk("R12 ctrl", d, 8'h00);
        reg_rd(2'd3, d); chk("R12 thresh", d, 8'h00);
        reg_rd(2'd1, d); chk("R1 size", d, 8'h42);
        reg_wr(2'd1, 8'hFF);
        reg_rd(2'd1, d); chk("R1 size after write", d, 8'h42);
    endtask

    task automatic t_order_empty;
        logic [DW-1:0] a, b, c;
        logic [7:0] d;
        int base;
        base = nbeats;
        frame(3'b101, 0, 8'h00, a, b, c);
        wait_cyc(4);
        chk("R2 beats", nbeats - base, 2);
        chk("R2 first lane0", seq_log[base], a);
        chk("R2 second lane2", seq_log[base+1], c);
        chk("R3 ring slot0", ring_log[0], a);
        chk("R3 addr after 2", mem_waddr, 2);
        chk("R6 no count hit", status[0], 0);
        frame(3'b000, 0, 8'h00, a, b, c);
        @(negedge clk);
        chk("R7 empty frame sets", status[0], 1);
        chk("R8 set without enable, irq low", irq, 0);
        reg_wr(2'd0, 8'h00);
        @(negedge clk);
        chk("R9 write zero keeps", status[0], 1);
        reg_wr(2'd0, 8'hFF);
        reg_rd(2'd0, d);
        chk("R9 cleared and reserved zero", d, 8'h00);
        frame(3'b000, 0, 8'h00, a, b, c);
        @(negedge clk);
        chk("R7 idle frame no set", status[0], 0);
    endtask

    task automatic t_threshold;
        logic [DW-1:0] a, b, c;
        reg_wr(2'd3, 8'd3);
        reg_wr(2'd2, 8'h01);
        reg_wr(2'd0, 8'h05);
        frame(3'b001, 0, 8'h00, a, b, c); wait_cyc(3);
        frame(3'b001, 0, 8'h00, a, b, c); wait_cyc(3);
        chk("R6 below threshold", status[0], 0);
        chk("R8 irq low", irq, 0);
        frame(3'b001, 0, 8'h00, a, b, c); wait_cyc(3);
        chk("R6 threshold reached", status[0], 1);
        chk("R8 irq enabled", irq, 1);
        reg_wr(2'd2, 8'h00);
        @(negedge clk);
        chk("R8 irq masked", irq, 0);
        chk("R8 flag kept", status[0], 1);
    endtask

    task automatic t_overrun;
        logic [DW-1:0] a0, a1, a2, b0, b1, b2;
        int base;
        reg_wr(2'd0, 8'h05);
        @(posedge clk); #2; mem_wready = 1'b0;
        base = nbeats;
        frame(3'b111, 0, 8'h00, a0, a1, a2);
        @(negedge clk);
        chk("R5 no drop yet", status[2], 0);
        frame(3'b111, 0, 8'h00, b0, b1, b2);
        @(negedge clk);
        chk("R5 overrun flag", status[2], 1);
        chk("R8 ovr irq disabled", irq, 0);
        wait_cyc(2);
        chk("R2 held valid", mem_wvalid, 1);
        chk("R2 held data", mem_wdata, a0);
        reg_wr(2'd2, 8'h04);
        @(negedge clk);
        chk("R8 ovr irq enabled", irq, 1);
        @(posedge clk); #2; mem_wready = 1'b1;
        wait_cyc(8);
        chk("R5 four written", nbeats - base, 4);
        chk("R5 order 3", seq_log[base+3], b0);
        chk("R2 order 0", seq_log[base], a0);
        reg_wr(2'd0, 8'h04);
        @(negedge clk);
        chk("R9 ovr cleared", status[2], 0);
        chk("R8 irq dropped", irq, 0);
    endtask

    task automatic t_set_wins;
        logic [DW-1:0] a, b, c;
        int base;
        @(posedge clk); #2; mem_wready = 1'b0;
        base = nbeats;
        frame(3'b111, 0, 8'h00, a, b, c);
        frame(3'b001, 0, 8'h00, a, b, c);
        frame(3'b001, 1, 8'h04, a, b, c);
        @(negedge clk);
        chk("R10 set beats clear", status[2], 1);
        reg_wr(2'd0, 8'h04);
        @(negedge clk);
        chk("R10 later clear", status[2], 0);
        @(posedge clk); #2; mem_wready = 1'b1;
        wait_cyc(8);
        chk("R5 full drain", nbeats - base, 4);
    endtask

    task automatic t_restart;
        logic [DW-1:0] a, b, c;
        reg_wr(2'd3, 8'd2);
        reg_wr(2'd0, 8'h05);
        frame(3'b001, 0, 8'h00, a, b, c); wait_cyc(3);
        reg_wr(2'd0, 8'h01);
        frame(3'b001, 0, 8'h00, a, b, c); wait_cyc(3);
        chk("R11 count restarted", status[0], 0);
        frame(3'b001, 0, 8'h00, a, b, c); wait_cyc(3);
        chk("R11 hit after restart", status[0], 1);
    endtask

    task automatic t_wrap;
        logic [DW-1:0] a, b, c;
        logic [7:0] d;
        reg_wr(2'd2, 8'h80);
        @(negedge clk);
        chk("R4 pointer cleared", mem_waddr, 0);
        reg_rd(2'd2, d);
        chk("R4 bit7 reads zero", d[7], 0);
        reg_wr(2'd3, 8'd0);
        reg_wr(2'd0, 8'h05);
        for (int k = 0; k < 85; k++) begin
            frame(3'b111, 0, 8'h00, a, b, c);
            wait_cyc(2);
        end
        wait_cyc(3);
        chk("R3 addr 255", mem_waddr, 255);
        chk("R6 zero means 256, not yet", status[0], 0);
        frame(3'b111, 0, 8'h00, a, b, c);
        wait_cyc(5);
        chk("R6 hit at 256", status[0], 1);
        chk("R3 wrapped addr", mem_waddr, 2);
        chk("R3 slot0 rewritten", ring_log[0], b);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order_empty();
        t_threshold();
        t_overrun();
        t_set_wins();
        t_restart();
        t_wrap();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule